// File: doc/BRIEF.md
# Processor Status Flag Register

This block keeps the eight-bit condition and mode byte of a small accumulator-based 8-bit CPU core. The byte has six live flags: carry, zero, interrupt-disable, decimal mode, overflow and negative. It also has a constant bit that always reads one and a bit that is always held at zero. The rest of the core drives the register through single-cycle strobes. There are three strobes that each set one mode flag. There is a whole-byte restore, used when status comes back from the stack. There is a flag update from the arithmetic unit, and a zero/negative update from register-to-register moves. All updates take effect at the next rising clock edge, and the current byte is always visible on `status`.

A store operation drives none of the strobes, so the register keeps every flag through it. Instruction decode, stack addressing and interrupt sequencing sit outside this block.

Top module: `status_flags`

## Requirements
- R1: After reset, `status` reads 8'h24: interrupt-disable (bit 2) and the constant bit 5 are set, and every other bit is clear.
- R2: The bit positions of `status` are fixed as follows. Bit 0 is carry, bit 1 is zero, bit 2 is interrupt-disable, bit 3 is decimal, bit 4 always reads 0, bit 5 always reads 1, bit 6 is overflow and bit 7 is negative.
- R3: When `restore_en` is high, the next `status` equals `restore_byte` with bit 5 forced to 1 and bit 4 forced to 0.
- R4: `set_carry`, `set_intdis` and `set_decimal` each set their own bit (0, 2 and 3) to 1 one cycle later. No other bit changes.
- R5: When `alu_we` is high, carry takes `alu_carry` and overflow takes `alu_ovf`. Zero is set exactly when `alu_result` is 0, and negative takes `alu_result[7]`. Interrupt-disable and decimal do not change.
- R6: When `xfer_we` is high and `alu_we` is low, zero and negative follow `xfer_value`. Zero is set when the value is 0, and negative takes bit 7 of the value. Carry, interrupt-disable, decimal and overflow do not change.
- R7: A restore has priority over all other strobes in the same cycle.
- R8: When `alu_we` and `xfer_we` are both high, zero and negative follow `alu_result`.
- R9: A set strobe that arrives in the same cycle as an arithmetic update wins for its own bit. `set_carry` together with `alu_we` leaves carry at 1.
- R10: With no strobe high, as during a store, `status` holds its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| set_carry | input | 1 | Set the carry flag |
| set_intdis | input | 1 | Set the interrupt-disable flag |
| set_decimal | input | 1 | Set the decimal-mode flag |
| restore_en | input | 1 | Load the whole byte from `restore_byte` |
| restore_byte | input | 8 | Byte to restore, for example one pulled from the stack |
| alu_we | input | 1 | Apply the arithmetic-unit flags |
| alu_carry | input | 1 | Carry out of the arithmetic unit |
| alu_ovf | input | 1 | Signed overflow from the arithmetic unit |
| alu_result | input | 8 | Arithmetic result, source of zero and negative |
| xfer_we | input | 1 | Apply the flags of a register transfer |
| xfer_value | input | 8 | Value moved by the transfer |
| status | output | 8 | Current status byte |

## Verification
The bench restores 8'h00 and 8'hFF. A design that copied the byte verbatim would show bit 5 clear on the first and bit 4 set on the second. It fires transfers after carry, decimal and overflow have been set, so a transfer path that wrote the arithmetic flags would destroy them. It also stacks a restore on top of every other strobe, an arithmetic update on top of a transfer, and `set_carry` on top of an arithmetic carry of zero. A wrong priority order therefore shows up as a wrong byte one cycle later.

// File: rtl/status_flags.sv
module status_flags #(
  parameter logic [7:0] RESET_VALUE = 8'h24
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       set_carry,
  input  logic       set_intdis,
  input  logic       set_decimal,
  input  logic       restore_en,
  input  logic [7:0] restore_byte,
  input  logic       alu_we,
  input  logic       alu_carry,
  input  logic       alu_ovf,
  input  logic [7:0] alu_result,
  input  logic       xfer_we,
  input  logic [7:0] xfer_value,
  output logic [7:0] status
);

  logic c_q, z_q, i_q, d_q, v_q, n_q;
  logic c_d, z_d, i_d, d_d, v_d, n_d;

  always_comb begin
    c_d = c_q; z_d = z_q; i_d = i_q; d_d = d_q; v_d = v_q; n_d = n_q;
    if (restore_en) begin
      {n_d, v_d} = restore_byte[7:6];
      {d_d, i_d, z_d, c_d} = restore_byte[3:0];
    end else begin
      if (alu_we) begin
        c_d = alu_carry;
        v_d = alu_ovf;
        z_d = (alu_result == 8'h00);
        n_d = alu_result[7];
      end else if (xfer_we) begin
        z_d = (xfer_value == 8'h00);
        n_d = xfer_value[7];
      end
      if (set_carry)   c_d = 1'b1;
      if (set_intdis)  i_d = 1'b1;
      if (set_decimal) d_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      {n_q, v_q} <= RESET_VALUE[7:6];
      {d_q, i_q, z_q, c_q} <= RESET_VALUE[3:0];
    end else begin
      c_q <= c_d; z_q <= z_d; i_q <= i_d;
      d_q <= d_d; v_q <= v_d; n_q <= n_d;
    end
  end

  assign status = {n_q, v_q, 1'b1, 1'b0, d_q, i_q, z_q, c_q};

  AST_RESTORE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    restore_en |=> status == (($past(restore_byte) | 8'h20) & 8'hEF)); // R7
  AST_SET_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
    (set_carry && !restore_en) |=> status[0]); // R9
  AST_XFER_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_we && !alu_we && !restore_en && !set_carry && !set_intdis && !set_decimal)
    |=> ({status[6], status[3:0] & 4'b1101} == $past({status[6], status[3:0] & 4'b1101}))); // R6
  AST_ALU_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (alu_we && !restore_en) |=> status[1] == ($past(alu_result) == 8'h00)); // R5
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(restore_en || alu_we || xfer_we || set_carry || set_intdis || set_decimal)
    |=> $stable(status)); // R10

endmodule

// File: tb/status_flags_tb.sv
`timescale 1ns/1ps
module status_flags_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic set_carry = 0, set_intdis = 0, set_decimal = 0;
  logic restore_en = 0, alu_we = 0, alu_carry = 0, alu_ovf = 0, xfer_we = 0;
  logic [7:0] restore_byte = 0, alu_result = 0, xfer_value = 0;
  logic [7:0] status;

  int checks = 0;
  int errors = 0;
  logic [7:0] model;
  logic [7:0] exp_q[$];
  string tag_q[$];

  always #2.5 clk = ~clk;

  status_flags u_dut (
    .clk(clk), .rst_n(rst_n), .set_carry(set_carry), .set_intdis(set_intdis),
    .set_decimal(set_decimal), .restore_en(restore_en), .restore_byte(restore_byte),
    .alu_we(alu_we), .alu_carry(alu_carry), .alu_ovf(alu_ovf), .alu_result(alu_result),
    .xfer_we(xfer_we), .xfer_value(xfer_value), .status(status)
  );

  task automatic compare(input logic [7:0] exp, input string tag);
    checks++;
    if (status !== exp) begin
      errors++;
      $display("FAIL %s: status=%h expected=%h", tag, status, exp);
    end
  endtask

  task automatic op(input logic r, input logic [7:0] rb, input logic sc, input logic si,
                    input logic sd, input logic aw, input logic ac, input logic av,
                    input logic [7:0] ar, input logic xw, input logic [7:0] xv,
                    input string tag);
    @(negedge clk);
    restore_en = r; restore_byte = rb; set_carry = sc; set_intdis = si; set_decimal = sd;
    alu_we = aw; alu_carry = ac; alu_ovf = av; alu_result = ar; xfer_we = xw; xfer_value = xv;
    if (r) model = (rb | 8'h20) & 8'hEF;
    else begin
      if (aw) begin
        model[0] = ac; model[6] = av; model[1] = (ar == 0); model[7] = ar[7];
      end else if (xw) begin
        model[1] = (xv == 0); model[7] = xv[7];
      end
      if (sc) model[0] = 1'b1;
      if (si) model[2] = 1'b1;
      if (sd) model[3] = 1'b1;
    end
    exp_q.push_back(model);
    tag_q.push_back(tag);
  endtask

  always @(posedge clk) begin
    if (rst_n) begin
      #1;
      if (exp_q.size() > 0) compare(exp_q.pop_front(), tag_q.pop_front());
    end
  end

  initial begin
    for (int k = 0; k < 20000; k++) @(posedge clk);
    errors++;
    $display("FAIL watchdog: status=%h expected=done", status);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    compare(8'h24, "R1 reset value");
    model = 8'h24;
    rst_n = 1'b1;
    op(0, 0, 1, 0, 0, 0, 0, 0, 0, 0, 0, "R4 set carry");
    op(0, 0, 0, 0, 1, 0, 0, 0, 0, 0, 0, "R2 R4 set decimal bit 3");
    op(0, 0, 0, 0, 0, 1, 0, 1, 8'h00, 0, 0, "R5 alu zero result");
    op(0, 0, 0, 0, 0, 1, 1, 0, 8'h80, 0, 0, "R5 alu negative result");
    op(0, 0, 0, 0, 0, 1, 1, 1, 8'h41, 0, 0, "R5 alu carry ovf");
    op(0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 8'h00, "R6 transfer zero");
    op(0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 8'hF0, "R6 transfer negative");
    op(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R10 idle hold");
    op(1, 8'h00, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R3 restore zero forces bit5");
    op(1, 8'hFF, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R3 restore ones clears bit4");
    op(1, 8'h00, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R3 restore zero again");
    op(0, 0, 0, 1, 0, 0, 0, 0, 0, 0, 0, "R4 set interrupt disable");
    op(1, 8'h01, 1, 1, 1, 1, 0, 1, 8'h80, 1, 8'h80, "R7 restore beats all");
    op(0, 0, 0, 0, 0, 1, 0, 0, 8'h05, 1, 8'h00, "R8 alu over transfer");
    op(0, 0, 1, 0, 0, 1, 0, 0, 8'h10, 0, 0, "R9 set carry beats alu");
    op(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R10 store leaves flags");
    @(negedge clk);
    restore_en = 0; set_carry = 0; set_intdis = 0; set_decimal = 0; alu_we = 0; xfer_we = 0;
    repeat (3) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule